// File: doc/BRIEF.md
# Shadow-flag register file with read poisoning

This block is a sixteen-entry, 64-bit register file with one write port and three read ports. Every write also stores a small set of attributes beside the value: whether the value is zero, its lowest and highest bits, and four alignment flags. A read port therefore delivers ready-made condition and alignment sources with no logic after the storage array.

Each entry also has a poison bit. One bulk command sets the poison bit on every entry in a single cycle, so a register set can be sealed before unvetted code runs. The next write to an entry clears its bit. A read of a poisoned entry on any port raises a per-port trap that carries the register number. The read data and attributes on that port are forced to zero, so no stale content leaks out. Reads are combinational. A write lands at the rising clock edge, and a read of the entry being written in the same cycle sees the incoming value.

Top module: `shadow_regfile`

## Requirements
- R1: After reset every entry reads value 0 with zero flag 1, lsb 0, msb 0, all four alignment flags 1, and no port traps.
- R2: A value written with wrEn high at a clock edge is returned by any read port selecting that entry after the edge.
- R3: rdZero of a port is 1 exactly when the value read is all zeros.
- R4: rdLsb and rdMsb of a port equal bit 0 and bit 63 of the value read.
- R5: rdAlign holds four flags per port at bits 4p+0 to 4p+3. Flag k (k = 0..3) is 1 when bits k down to 0 of the value read are all zero.
- R6: A cycle with poisonAll high and no write poisons every entry from the next edge. A read of a poisoned entry drives trapValid[p] high and trapIdx field p to the entry number, and forces data, rdZero, rdLsb, rdMsb and rdAlign of that port to 0.
- R7: A write to an entry clears its poison bit, and later reads of it return the written value with no trap.
- R8: When wrEn is high and a read port selects wrIdx in the same cycle, that port returns wrData and its attributes combinationally, with no trap even if the entry is poisoned.
- R9: When poisonAll and a write occur in the same cycle, the written entry ends up unpoisoned and every other entry ends up poisoned.
- R10: With wrEn low, the contents are unchanged whatever wrIdx and wrData hold.
- R11: Traps are per port. A port reading an unpoisoned entry shows trapValid 0 and trapIdx 0 while another port traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Entry to write |
| wrData | input | 64 | Value to write |
| poisonAll | input | 1 | Bulk command that poisons every entry |
| rdIdx | input | 12 | Entry selected by each read port, 4 bits per port, port p at bits 4p+3..4p |
| rdData | output | 192 | Read value per port, port p at bits 64p+63..64p |
| rdZero | output | 3 | Zero flag per port |
| rdLsb | output | 3 | Lowest bit of the value per port |
| rdMsb | output | 3 | Highest bit of the value per port |
| rdAlign | output | 12 | Four alignment flags per port |
| trapValid | output | 3 | Poisoned read on the port |
| trapIdx | output | 12 | Entry that trapped, per port, 0 when no trap |

## Verification
Three pairs of functions can land in the same cycle: a write with a read of the same entry, a write with the bulk poison command, and a trapping port with a clean one. The bench provokes the first by reading a poisoned entry while writing it, and it judges the result combinationally before the edge (new value, no trap) and again after the edge. The second is provoked by asserting poisonAll together with a write. It is judged on the following cycles by reading the written entry, which must not trap, and two other entries, which must trap with their own numbers.

// File: rtl/trf_pkg.sv
package trf_pkg;
  localparam int RF_DEPTH    = 16;
  localparam int RF_WIDTH    = 64;
  localparam int RF_RD_PORTS = 3;
  localparam int RF_IDX_W    = $clog2(RF_DEPTH);
  localparam int RF_ALIGN_N  = 4;

  // attributes kept beside every entry
  typedef struct packed {
    logic                  zero;
    logic                  lsb;
    logic                  msb;
    logic [RF_ALIGN_N-1:0] align;
  } attr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [RF_DEPTH-1:0]    wrSel;
    logic [RF_RD_PORTS-1:0] rdKill;
  } strobe_t;

  function automatic attr_t calcAttr(input logic [RF_WIDTH-1:0] v);
    attr_t                a;
    logic [RF_WIDTH-1:0]  mask;
    a.zero = (v == '0);
    a.lsb  = v[0];
    a.msb  = v[RF_WIDTH-1];
    for (int k = 0; k < RF_ALIGN_N; k++) begin
      mask       = (RF_WIDTH'(1) << (k + 1)) - RF_WIDTH'(1);
      a.align[k] = ~|(v & mask);
    end
    return a;
  endfunction
endpackage

// File: rtl/trf_ctrl.sv
module trf_ctrl
  import trf_pkg::*;
#(
  parameter int NUM_REGS = RF_DEPTH,
  parameter int NUM_RD   = RF_RD_PORTS,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [IW-1:0]        wrIdx,
  input  logic                 poisonAll,
  input  logic [NUM_RD*IW-1:0] rdIdx,
  output strobe_t              strb,
  output logic [NUM_RD-1:0]    trapValid,
  output logic [NUM_RD*IW-1:0] trapIdx
);
  logic [NUM_REGS-1:0] poisonQ;
  logic [NUM_REGS-1:0] wrSel;

  always_comb begin
    wrSel = '0;
    if (wrEn) wrSel[wrIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poisonQ <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wrSel[i])       poisonQ[i] <= 1'b0;
        else if (poisonAll) poisonQ[i] <= 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic [IW-1:0] idx;
    logic          kill;
    assign idx  = rdIdx[p*IW +: IW];
    assign kill = poisonQ[idx] && !wrSel[idx];
    assign trapValid[p]        = kill;
    assign trapIdx[p*IW +: IW] = kill ? idx : '0;
    assign strb.rdKill[p]      = kill;
  end

  assign strb.wrSel = wrSel;

  assert_bulk_poison_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poisonAll && !wrEn) |=> (&poisonQ));

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !poisonQ[$past(wrIdx)]);

  assert_poison_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (poisonAll && wrEn) |=> ($countones(poisonQ) == NUM_REGS - 1));
endmodule

// File: rtl/trf_dp.sv
module trf_dp
  import trf_pkg::*;
#(
  parameter int NUM_REGS = RF_DEPTH,
  parameter int DATA_W   = RF_WIDTH,
  parameter int NUM_RD   = RF_RD_PORTS,
  parameter int ALIGN_N  = RF_ALIGN_N,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobe_t                   strb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_RD*IW-1:0]      rdIdx,
  output logic [NUM_RD*DATA_W-1:0]  rdData,
  output logic [NUM_RD-1:0]         rdZero,
  output logic [NUM_RD-1:0]         rdLsb,
  output logic [NUM_RD-1:0]         rdMsb,
  output logic [NUM_RD*ALIGN_N-1:0] rdAlign
);
  logic [DATA_W-1:0] dataQ [NUM_REGS];
  attr_t             attrQ [NUM_REGS];
  attr_t             newAttr;

  assign newAttr = calcAttr(wrData);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        dataQ[i] <= '0;
        attrQ[i] <= '{zero: 1'b1, lsb: 1'b0, msb: 1'b0, align: '1};
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strb.wrSel[i]) begin
          dataQ[i] <= wrData;
          attrQ[i] <= newAttr;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] srcData;
    attr_t             srcAttr;
    assign idx = rdIdx[p*IW +: IW];
    always_comb begin
      if (strb.wrSel[idx]) begin
        srcData = wrData;
        srcAttr = newAttr;
      end else begin
        srcData = dataQ[idx];
        srcAttr = attrQ[idx];
      end
      if (strb.rdKill[p]) begin
        srcData = '0;
        srcAttr = '0;
      end
    end
    assign rdData[p*DATA_W +: DATA_W]    = srcData;
    assign rdZero[p]                     = srcAttr.zero;
    assign rdLsb[p]                      = srcAttr.lsb;
    assign rdMsb[p]                      = srcAttr.msb;
    assign rdAlign[p*ALIGN_N +: ALIGN_N] = srcAttr.align;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    assert_stored_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      attrQ[i].zero == (dataQ[i] == '0));
    assert_stored_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      attrQ[i].align[0] == !dataQ[i][0]);
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import trf_pkg::*;
#(
  parameter int NUM_REGS = RF_DEPTH,
  parameter int DATA_W   = RF_WIDTH,
  parameter int NUM_RD   = RF_RD_PORTS,
  parameter int ALIGN_N  = RF_ALIGN_N,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wrEn,
  input  logic [IW-1:0]             wrIdx,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      poisonAll,
  input  logic [NUM_RD*IW-1:0]      rdIdx,
  output logic [NUM_RD*DATA_W-1:0]  rdData,
  output logic [NUM_RD-1:0]         rdZero,
  output logic [NUM_RD-1:0]         rdLsb,
  output logic [NUM_RD-1:0]         rdMsb,
  output logic [NUM_RD*ALIGN_N-1:0] rdAlign,
  output logic [NUM_RD-1:0]         trapValid,
  output logic [NUM_RD*IW-1:0]      trapIdx
);
  strobe_t strb;

  trf_ctrl #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx),
    .poisonAll(poisonAll), .rdIdx(rdIdx), .strb(strb),
    .trapValid(trapValid), .trapIdx(trapIdx)
  );

  trf_dp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .ALIGN_N(ALIGN_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData), .rdIdx(rdIdx),
    .rdData(rdData), .rdZero(rdZero), .rdLsb(rdLsb), .rdMsb(rdMsb), .rdAlign(rdAlign)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_trapchk
    assert_trap_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trapValid[p] |-> (rdData[p*DATA_W +: DATA_W] == '0 && !rdZero[p] &&
                        rdAlign[p*ALIGN_N +: ALIGN_N] == '0));
    assert_bypass_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && rdIdx[p*IW +: IW] == wrIdx) |-> (rdData[p*DATA_W +: DATA_W] == wrData));
  end
endmodule

// File: tb/shadow_regfile_tb.sv
module shadow_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'h10,
    64'h8, 64'h6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDE0};

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wrEn = 0;
  logic [3:0]   wrIdx = 0;
  logic [63:0]  wrData = 0;
  logic         poisonAll = 0;
  logic [11:0]  rdIdx = 0;
  logic [191:0] rdData;
  logic [2:0]   rdZero, rdLsb, rdMsb, trapValid;
  logic [11:0]  rdAlign, trapIdx;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .poisonAll(poisonAll), .rdIdx(rdIdx), .rdData(rdData), .rdZero(rdZero),
    .rdLsb(rdLsb), .rdMsb(rdMsb), .rdAlign(rdAlign), .trapValid(trapValid),
    .trapIdx(trapIdx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expAlign(input logic [63:0] v);
    logic [3:0] a;
    for (int k = 0; k < 4; k++) a[k] = ((v & ((64'd1 << (k + 1)) - 1)) == 0);
    return a;
  endfunction

  task automatic setRd(input int p, input logic [3:0] idx);
    rdIdx[p*4 +: 4] = idx;
  endtask

  // checks a clean read on port p
  task automatic chkRead(input string req, input int p, input logic [63:0] v);
    chk({req, " data"}, rdData[p*64 +: 64], v);
    chk({req, " zero"}, 64'(rdZero[p]), 64'(v == 0));
    chk({req, " lsb"}, 64'(rdLsb[p]), 64'(v[0]));
    chk({req, " msb"}, 64'(rdMsb[p]), 64'(v[63]));
    chk({req, " align"}, 64'(rdAlign[p*4 +: 4]), 64'(expAlign(v)));
    chk({req, " notrap"}, 64'(trapValid[p]), 64'd0);
  endtask

  task automatic chkTrap(input string req, input int p, input logic [3:0] idx);
    chk({req, " trap"}, 64'(trapValid[p]), 64'd1);
    chk({req, " trapIdx"}, 64'(trapIdx[p*4 +: 4]), 64'(idx));
    chk({req, " data0"}, rdData[p*64 +: 64], 64'd0);
    chk({req, " flags0"}, 64'({rdZero[p], rdLsb[p], rdMsb[p], rdAlign[p*4 +: 4]}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 16; r++) begin
      setRd(0, 4'(r)); #1;
      chkRead("R1", 0, 64'd0);
    end

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = 1; wrIdx = 4'(i + 3); wrData = VEC[i]; setRd(0, 4'd15);
      @(negedge clk);
      wrEn = 0; setRd(i % 3, 4'(i + 3)); #1;
      chkRead("R2 R3 R4 R5", i % 3, VEC[i]);
    end

    // R10 disabled write has no effect
    @(negedge clk);
    wrEn = 0; wrIdx = 4'd4; wrData = 64'hDEAD;
    @(negedge clk);
    setRd(1, 4'd4); #1;
    chkRead("R10", 1, VEC[1]);

    // R6 R11 bulk poison
    @(negedge clk);
    poisonAll = 1;
    @(negedge clk);
    poisonAll = 0; setRd(0, 4'd9); setRd(1, 4'd5); setRd(2, 4'd0); #1;
    chkTrap("R6", 0, 4'd9);
    chkTrap("R6", 1, 4'd5);
    chkTrap("R6 R11", 2, 4'd0);

    // R7 write clears poison, R11 other ports still trap
    wrEn = 1; wrIdx = 4'd5; wrData = 64'hABC; setRd(1, 4'd1);
    @(negedge clk);
    wrEn = 0; setRd(1, 4'd5); #1;
    chkRead("R7", 1, 64'hABC);
    chkTrap("R7 R11", 0, 4'd9);
    chk("R11 idx clean port", 64'(trapIdx[4 +: 4]), 64'd0);

    // R8 bypass on a poisoned entry
    wrEn = 1; wrIdx = 4'd9; wrData = 64'h40; setRd(2, 4'd9); #1;
    chkRead("R8", 2, 64'h40);
    @(negedge clk);
    wrEn = 0; #1;
    chkRead("R8 after edge", 2, 64'h40);

    // R9 poison and write together
    wrEn = 1; poisonAll = 1; wrIdx = 4'd2; wrData = 64'h7; setRd(0, 4'd3);
    @(negedge clk);
    wrEn = 0; poisonAll = 0; setRd(0, 4'd2); setRd(1, 4'd9); setRd(2, 4'd5); #1;
    chkRead("R9", 0, 64'h7);
    chkTrap("R9", 1, 4'd9);
    chkTrap("R9", 2, 4'd5);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule